// File: doc/BRIEF.md
# Accumulator CPU Core (Instruction Subset)

This block is a small 8-bit accumulator processor core that runs a reduced instruction set. It holds an accumulator `A`, an index register `X`, a 14-bit program counter and two condition flags, zero (Z) and carry (C). It fetches opcodes and operands over a byte-wide memory port and executes each instruction in a fixed number of cycles. The subset covers add with and without carry, logical AND, a one-bit left shift of the accumulator, bit clear in memory, three conditional relative branches and a debug-stop opcode. Any opcode outside the subset halts the core and raises an illegal-opcode flag.

The memory port gives a combinational read of the addressed byte in the same cycle. A write is committed at the clock edge. Two direct addresses are special. Direct address 0x0E stands for the byte whose address is held in `X`. Direct address 0x0F stands for the `X` register itself, so `X` can be read, and changed with bit clear, through direct addressing. `op_start` marks each opcode-fetch cycle, so a system can track instruction boundaries.

Top module: `acc8_core`

## Requirements
- R1: After reset `A` is 0x00, `X` equals the parameter `X_RESET` (default 0xFF), Z and C are 0, the PC equals `RESET_PC` (default 0x040), and `halted` and `illegal` are low.
- R2: Opcodes 0xAB (immediate, 2 cycles) and 0xBB (direct, 3 cycles) set A = A + M. Opcodes 0xA9 (immediate, 2 cycles) and 0xB9 (direct, 3 cycles) set A = A + M + C. C takes the carry out of bit 7, and Z is set exactly when the 8-bit result is zero.
- R3: Opcodes 0xA4 (immediate, 2 cycles) and 0xB4 (direct, 3 cycles) set A = A & M. They update Z and leave C unchanged.
- R4: Opcode 0x48 takes 1 cycle. It shifts A left by one place, copies the old bit 7 into C, loads 0 into bit 0 and updates Z.
- R5: Opcodes 0x34 (taken when C = 0), 0x35 (taken when C = 1) and 0x37 (taken when Z = 1) take 3 cycles each. When taken, the PC becomes the opcode address + 2 + the operand byte read as a signed two's-complement offset. Otherwise the PC becomes the opcode address + 2.
- R6: Opcode 0x11 + 2·n (n = 0..7, with n held in opcode bits 3:1) takes 5 cycles. It clears only bit n of the directly addressed byte and leaves A, Z and C unchanged.
- R7: Direct address 0x0E accesses the byte at address `X`. Direct address 0x0F accesses the `X` register, and a write there does not reach memory. No access changes `X` except a bit clear aimed at it.
- R8: Opcode 0xBF stops execution and raises `halted` with `illegal` low. After that the core makes no memory access and the PC and A hold, until reset.
- R9: Any other opcode raises both `halted` and `illegal` after its 1-cycle fetch, with the PC one past that opcode.
- R10: `mem_rd` and `mem_wr` are never high together, and a memory write happens only in the last cycle of a bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | PC_W | Byte address for the memory port |
| mem_rd | output | 1 | Read strobe, data expected on mem_rdata in the same cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe, committed at the clock edge |
| mem_wdata | output | 8 | Write data |
| acc | output | 8 | Accumulator A |
| xreg | output | 8 | Index register X |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| pc | output | PC_W | Program counter |
| op_start | output | 1 | High in each opcode-fetch cycle |
| halted | output | 1 | Core stopped |
| illegal | output | 1 | Stop caused by an unimplemented opcode |

## Verification
The hardest situation to reach from the ports is an indexed access through a non-trivial `X`. The subset has no instruction that loads `X`, so the program first carves a chosen index out of the all-ones reset value with six bit clears aimed at direct address 0x0F. Only then does it read through 0x0E. A backward branch is also hard to reach, because it needs the flags set up by earlier arithmetic. The program uses a forward branch to land past the branch target and then takes a negative offset back to it. Taken and untaken branches are interleaved so that both PC outcomes of every condition are seen.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

   localparam int DW = 8;

   typedef enum logic [2:0] {
      K_ADC, K_ADD, K_AND, K_ASL, K_BR, K_BCLR, K_STOP, K_BAD
   } kind_e;

   typedef enum logic [1:0] {
      M_INH, M_IMM, M_DIR, M_REL
   } mode_e;

   typedef enum logic [1:0] {
      C_CC = 2'd0, C_CS = 2'd1, C_EQ = 2'd2
   } cond_e;

   typedef struct packed {
      kind_e      kind;
      mode_e      mode;
      cond_e      cond;
      logic [2:0] bitn;
   } dec_t;

   typedef enum logic [2:0] {
      S_FETCH, S_OPND, S_DATA, S_RMW, S_WRITE, S_HALT
   } state_e;

   localparam logic [DW-1:0] ADDR_VIA_X = 8'h0E;
   localparam logic [DW-1:0] ADDR_X_REG = 8'h0F;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
   import acc8_pkg::*;
(
   input  logic [DW-1:0] op,
   output dec_t          d
);

   always_comb begin
      d = '{kind: K_BAD, mode: M_INH, cond: C_CC, bitn: 3'd0};
      unique case (op)
         8'hA9: begin d.kind = K_ADC; d.mode = M_IMM; end
         8'hB9: begin d.kind = K_ADC; d.mode = M_DIR; end
         8'hAB: begin d.kind = K_ADD; d.mode = M_IMM; end
         8'hBB: begin d.kind = K_ADD; d.mode = M_DIR; end
         8'hA4: begin d.kind = K_AND; d.mode = M_IMM; end
         8'hB4: begin d.kind = K_AND; d.mode = M_DIR; end
         8'h48: d.kind = K_ASL;
         8'h34: begin d.kind = K_BR; d.mode = M_REL; d.cond = C_CC; end
         8'h35: begin d.kind = K_BR; d.mode = M_REL; d.cond = C_CS; end
         8'h37: begin d.kind = K_BR; d.mode = M_REL; d.cond = C_EQ; end
         8'hBF: d.kind = K_STOP;
         default: begin
            // bit clear family: high nibble 1, odd opcode, bit number in [3:1]
            if (op[7:4] == 4'h1 && op[0]) begin
               d.kind = K_BCLR;
               d.mode = M_DIR;
               d.bitn = op[3:1];
            end
         end
      endcase
   end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
   import acc8_pkg::*;
#(
   parameter bit RIPPLE = 1'b0
)(
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] m,
   input  logic          cin,
   input  kind_e         kind,
   output logic [DW-1:0] res,
   output logic          z,
   output logic          cout
);

   logic          cy_in;
   logic [DW-1:0] sum;
   logic          sum_co;

   assign cy_in = (kind == K_ADC) & cin;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DW:0] cy;
         assign cy[0] = cy_in;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i]  = a[i] ^ m[i] ^ cy[i];
            assign cy[i+1] = (a[i] & m[i]) | (cy[i] & (a[i] ^ m[i]));
         end
         assign sum_co = cy[DW];
      end else begin : g_behav
         assign {sum_co, sum} = {1'b0, a} + {1'b0, m} + (DW+1)'(cy_in);
      end
   endgenerate

   always_comb begin
      res  = a;
      cout = cin;
      unique case (kind)
         K_ADC, K_ADD: begin res = sum;   cout = sum_co; end
         K_AND:        begin res = a & m; cout = cin;    end
         K_ASL:        begin res = {a[DW-2:0], 1'b0}; cout = a[DW-1]; end
         default:      begin res = a;     cout = cin;    end
      endcase
      z = (res == '0);
   end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
   import acc8_pkg::*;
#(
   parameter int          PC_W       = 14,
   parameter int unsigned RESET_PC   = 32'h40,
   parameter logic [7:0]  X_RESET    = 8'hFF,
   parameter bit          RIPPLE_ADD = 1'b0
)(
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] mem_addr,
   output logic            mem_rd,
   input  logic [7:0]      mem_rdata,
   output logic            mem_wr,
   output logic [7:0]      mem_wdata,
   output logic [7:0]      acc,
   output logic [7:0]      xreg,
   output logic            flag_z,
   output logic            flag_c,
   output logic [PC_W-1:0] pc,
   output logic            op_start,
   output logic            halted,
   output logic            illegal
);

   localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_PC);
   localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

   generate
      if (PC_W < 9 || PC_W > 16) begin : g_bad_pcw
         $error("acc8_core: PC_W must lie in 9..16");
      end
      if (RESET_PC >= (32'd1 << PC_W)) begin : g_bad_rst
         $error("acc8_core: RESET_PC outside the address range");
      end
   endgenerate

   state_e          st_q;
   dec_t            dec_now, dec_q, cur;
   logic [PC_W-1:0] pc_q;
   logic [DW-1:0]   acc_q, x_q, ea_q, data_q;
   logic            z_q, c_q, halt_q, bad_q;

   logic [DW-1:0]   eff, opnd, alu_m, alu_res, clr_mask;
   logic            ea_is_x, alu_go, taken, alu_z, alu_c;

   acc8_decode u_dec (.op(mem_rdata), .d(dec_now));

   assign cur = (st_q == S_FETCH) ? dec_now : dec_q;

   acc8_alu #(.RIPPLE(RIPPLE_ADD)) u_alu (
      .a(acc_q), .m(alu_m), .cin(c_q), .kind(cur.kind),
      .res(alu_res), .z(alu_z), .cout(alu_c)
   );

   // direct-address window: 0x0E goes through X, 0x0F is X itself
   always_comb begin
      ea_is_x  = (ea_q == ADDR_X_REG);
      eff      = (ea_q == ADDR_VIA_X) ? x_q : ea_q;
      opnd     = ea_is_x ? x_q : mem_rdata;
      alu_m    = (st_q == S_OPND) ? mem_rdata : opnd;
      clr_mask = DW'(1) << dec_q.bitn;
      unique case (dec_q.cond)
         C_CC:    taken = ~c_q;
         C_CS:    taken = c_q;
         C_EQ:    taken = z_q;
         default: taken = 1'b0;
      endcase
      alu_go = (st_q == S_FETCH && dec_now.kind == K_ASL)
             | (st_q == S_OPND && dec_q.mode == M_IMM)
             | (st_q == S_DATA && dec_q.mode == M_DIR
                && dec_q.kind inside {K_ADC, K_ADD, K_AND});
   end

   always_comb begin
      mem_addr  = pc_q;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_wdata = data_q & ~clr_mask;
      unique case (st_q)
         S_FETCH, S_OPND: mem_rd = 1'b1;
         S_DATA: if (dec_q.kind != K_BR) begin
            mem_addr = PC_W'(eff);
            mem_rd   = ~ea_is_x;
         end
         S_RMW:   mem_addr = PC_W'(eff);
         S_WRITE: begin
            mem_addr = PC_W'(eff);
            mem_wr   = ~ea_is_x;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_FETCH;
         pc_q   <= PC_RST;
         acc_q  <= '0;
         x_q    <= X_RESET;
         z_q    <= 1'b0;
         c_q    <= 1'b0;
         halt_q <= 1'b0;
         bad_q  <= 1'b0;
         dec_q  <= '{kind: K_BAD, mode: M_INH, cond: C_CC, bitn: 3'd0};
         ea_q   <= '0;
         data_q <= '0;
      end else begin
         if (alu_go) begin
            acc_q <= alu_res;
            z_q   <= alu_z;
            c_q   <= alu_c;
         end
         unique case (st_q)
            S_FETCH: begin
               pc_q  <= pc_q + PC_ONE;
               dec_q <= dec_now;
               unique case (dec_now.kind)
                  K_ASL:  st_q <= S_FETCH;
                  K_STOP: begin halt_q <= 1'b1; st_q <= S_HALT; end
                  K_BAD:  begin halt_q <= 1'b1; bad_q <= 1'b1; st_q <= S_HALT; end
                  default: st_q <= S_OPND;
               endcase
            end
            S_OPND: begin
               pc_q <= pc_q + PC_ONE;
               ea_q <= mem_rdata;
               st_q <= (dec_q.mode == M_IMM) ? S_FETCH : S_DATA;
            end
            S_DATA: begin
               if (dec_q.kind == K_BR) begin
                  if (taken) pc_q <= pc_q + {{(PC_W-DW){ea_q[DW-1]}}, ea_q};
                  st_q <= S_FETCH;
               end else if (dec_q.kind == K_BCLR) begin
                  data_q <= opnd;
                  st_q   <= S_RMW;
               end else begin
                  st_q <= S_FETCH;
               end
            end
            S_RMW:   st_q <= S_WRITE;
            S_WRITE: begin
               if (ea_is_x) x_q <= mem_wdata;
               st_q <= S_FETCH;
            end
            default: st_q <= S_HALT;
         endcase
      end
   end

   assign acc      = acc_q;
   assign xreg     = x_q;
   assign flag_z   = z_q;
   assign flag_c   = c_q;
   assign pc       = pc_q;
   assign op_start = (st_q == S_FETCH);
   assign halted   = halt_q;
   assign illegal  = bad_q;

   // R10
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R10
   wr_only_bclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (dec_q.kind == K_BCLR));

   // R8
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (!mem_rd && !mem_wr && $stable(pc_q) && $stable(acc_q)));

   // R9
   bad_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted);

   // R4
   asl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_FETCH && dec_now.kind == K_ASL)
      |=> (c_q == $past(acc_q[DW-1]) && !acc_q[0]));

   // R3
   and_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_go && cur.kind == K_AND) |=> $stable(c_q));

   // R6
   bclr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WRITE) |=> ($stable(acc_q) && $stable(z_q) && $stable(c_q)));

   // R6
   bclr_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($countones(mem_wdata ^ data_q) <= 1));

   // R5
   branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DATA && dec_q.kind == K_BR && !taken) |=> $stable(pc_q));

endmodule

// File: tb/tb_acc8_core.sv
module tb_acc8_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [13:0] mem_addr, pc;
   logic        mem_rd, mem_wr, flag_z, flag_c, op_start, halted, illegal;
   logic [7:0]  mem_rdata, mem_wdata, acc, xreg;
   logic [7:0]  mem [256];
   int          checks = 0;
   int          fails  = 0;

   always #2 clk = ~clk;

   acc8_core dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .acc(acc), .xreg(xreg), .flag_z(flag_z), .flag_c(flag_c), .pc(pc),
      .op_start(op_start), .halted(halted), .illegal(illegal)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

   typedef struct packed {
      logic [7:0] addr, op, opd, npc;
      logic [3:0] cyc;
      logic [7:0] a, x;
      logic       z, c;
   } vec_t;

   // addr, opcode, operand, next pc, cycles, A, X, Z, C
   localparam vec_t TAB [27] = '{
      '{8'h40, 8'hAB, 8'h05, 8'h42, 4'd2, 8'h05, 8'hFF, 1'b0, 1'b0},
      '{8'h42, 8'hBB, 8'h21, 8'h44, 4'd3, 8'h84, 8'hFF, 1'b0, 1'b0},
      '{8'h44, 8'hB9, 8'h20, 8'h46, 4'd3, 8'h04, 8'hFF, 1'b0, 1'b1},
      '{8'h46, 8'hA9, 8'hFB, 8'h48, 4'd2, 8'h00, 8'hFF, 1'b1, 1'b1},
      '{8'h48, 8'hA4, 8'hFF, 8'h4A, 4'd2, 8'h00, 8'hFF, 1'b1, 1'b1},
      '{8'h4A, 8'hAB, 8'h81, 8'h4C, 4'd2, 8'h81, 8'hFF, 1'b0, 1'b0},
      '{8'h4C, 8'h48, 8'h00, 8'h4D, 4'd1, 8'h02, 8'hFF, 1'b0, 1'b1},
      '{8'h4D, 8'h48, 8'h00, 8'h4E, 4'd1, 8'h04, 8'hFF, 1'b0, 1'b0},
      '{8'h4E, 8'hB4, 8'h22, 8'h50, 4'd3, 8'h04, 8'hFF, 1'b0, 1'b0},
      '{8'h50, 8'h11, 8'h22, 8'h52, 4'd5, 8'h04, 8'hFF, 1'b0, 1'b0},
      '{8'h52, 8'h1F, 8'h22, 8'h54, 4'd5, 8'h04, 8'hFF, 1'b0, 1'b0},
      '{8'h54, 8'h1F, 8'h0F, 8'h56, 4'd5, 8'h04, 8'h7F, 1'b0, 1'b0},
      '{8'h56, 8'h1D, 8'h0F, 8'h58, 4'd5, 8'h04, 8'h3F, 1'b0, 1'b0},
      '{8'h58, 8'h17, 8'h0F, 8'h5A, 4'd5, 8'h04, 8'h37, 1'b0, 1'b0},
      '{8'h5A, 8'h15, 8'h0F, 8'h5C, 4'd5, 8'h04, 8'h33, 1'b0, 1'b0},
      '{8'h5C, 8'h13, 8'h0F, 8'h5E, 4'd5, 8'h04, 8'h31, 1'b0, 1'b0},
      '{8'h5E, 8'h11, 8'h0F, 8'h60, 4'd5, 8'h04, 8'h30, 1'b0, 1'b0},
      '{8'h60, 8'hBB, 8'h0E, 8'h62, 4'd3, 8'h13, 8'h30, 1'b0, 1'b0},
      '{8'h62, 8'hB4, 8'h0F, 8'h64, 4'd3, 8'h10, 8'h30, 1'b0, 1'b0},
      '{8'h64, 8'h34, 8'h02, 8'h68, 4'd3, 8'h10, 8'h30, 1'b0, 1'b0},
      '{8'h68, 8'h35, 8'h05, 8'h6A, 4'd3, 8'h10, 8'h30, 1'b0, 1'b0},
      '{8'h6A, 8'hAB, 8'hF0, 8'h6C, 4'd2, 8'h00, 8'h30, 1'b1, 1'b1},
      '{8'h6C, 8'h37, 8'h04, 8'h72, 4'd3, 8'h00, 8'h30, 1'b1, 1'b1},
      '{8'h72, 8'h35, 8'hFA, 8'h6E, 4'd3, 8'h00, 8'h30, 1'b1, 1'b1},
      '{8'h6E, 8'hA9, 8'h01, 8'h70, 4'd2, 8'h02, 8'h30, 1'b0, 1'b0},
      '{8'h70, 8'h34, 8'h02, 8'h74, 4'd3, 8'h02, 8'h30, 1'b0, 1'b0},
      '{8'h74, 8'h37, 8'h10, 8'h76, 4'd3, 8'h02, 8'h30, 1'b0, 1'b0}
   };

   function automatic string req_of(input logic [7:0] op, input logic [7:0] opd);
      if (op inside {8'h34, 8'h35, 8'h37}) return "R5";
      if (op == 8'h48) return "R4";
      if (opd inside {8'h0E, 8'h0F}) return "R7";
      if (op inside {8'hA9, 8'hAB, 8'hB9, 8'hBB}) return "R2";
      if (op inside {8'hA4, 8'hB4}) return "R3";
      return "R6";
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'h20] = 8'h80;
      mem[8'h21] = 8'h7F;
      mem[8'h22] = 8'hFF;
      mem[8'h30] = 8'h0F;
      for (int i = 0; i < 27; i++) begin
         mem[TAB[i].addr] = TAB[i].op;
         if (TAB[i].op != 8'h48) mem[TAB[i].addr + 8'd1] = TAB[i].opd;
      end
      mem[8'h76] = 8'hBF;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(acc == 8'h00, "R1", "acc", 16'(acc), 16'h00);
      chk(xreg == 8'hFF, "R1", "xreg", 16'(xreg), 16'hFF);
      chk({flag_z, flag_c} == 2'b00, "R1", "flags", 16'({flag_z, flag_c}), 16'h0);
      chk(pc == 14'h040, "R1", "pc", 16'(pc), 16'h40);
      chk({halted, illegal} == 2'b00, "R1", "halt", 16'({halted, illegal}), 16'h0);
      rst_n = 1'b1;

      // table walk, one instruction per entry
      for (int i = 0; i < 27; i++) begin
         int n;
         string r;
         r = req_of(TAB[i].op, TAB[i].opd);
         chk(op_start && pc == 14'(TAB[i].addr), r, "start pc", 16'(pc), 16'(TAB[i].addr));
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!op_start && n < 12);
         chk(n == int'(TAB[i].cyc), r, "cycles", 16'(n), 16'(TAB[i].cyc));
         chk(pc == 14'(TAB[i].npc), r, "next pc", 16'(pc), 16'(TAB[i].npc));
         chk(acc == TAB[i].a, r, "acc", 16'(acc), 16'(TAB[i].a));
         chk(xreg == TAB[i].x, r, "xreg", 16'(xreg), 16'(TAB[i].x));
         chk({flag_z, flag_c} == {TAB[i].z, TAB[i].c}, r, "flags",
             16'({flag_z, flag_c}), 16'({TAB[i].z, TAB[i].c}));
      end

      // R6 memory effect of bit clears; R7 index window never touched memory
      chk(mem[8'h22] == 8'h7E, "R6", "mem22", 16'(mem[8'h22]), 16'h7E);
      chk(mem[8'h30] == 8'h0F, "R7", "mem30", 16'(mem[8'h30]), 16'h0F);
      chk(mem[8'h0F] == 8'h00, "R7", "mem0F", 16'(mem[8'h0F]), 16'h00);

      // R8 stop opcode
      chk(op_start && pc == 14'h076, "R8", "stop pc", 16'(pc), 16'h76);
      @(negedge clk);
      chk(halted && !illegal, "R8", "halt flags", 16'({halted, illegal}), 16'b10);
      chk(pc == 14'h077, "R8", "pc after stop", 16'(pc), 16'h77);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         // R10 and R8: no bus activity while stopped
         chk(!mem_rd && !mem_wr && pc == 14'h077 && acc == 8'h02, "R8", "quiet",
             16'({mem_rd, mem_wr}), 16'h0);
      end

      // R9 unimplemented opcode
      rst_n = 1'b0;
      mem[8'h40] = 8'h42;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(op_start && !halted, "R9", "restart", 16'({op_start, halted}), 16'b10);
      @(negedge clk);
      chk(halted && illegal, "R9", "illegal flags", 16'({halted, illegal}), 16'b11);
      chk(pc == 14'h041, "R9", "pc", 16'(pc), 16'h41);
      chk(acc == 8'h00, "R9", "acc", 16'(acc), 16'h00);
      @(negedge clk);
      chk(!mem_rd && !mem_wr, "R10", "bus idle", 16'({mem_rd, mem_wr}), 16'h0);

      summary();
      $finish;
   end

endmodule